// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block sequences an 8-bit successive approximation conversion. The DAC, the comparator and any track-and-hold sit outside it. The controller holds a trial code register and a one-hot weight register. It presents the trial code to the DAC and loads it with a one-cycle strobe. It then raises a settle request that lets an external delay counter run. When that counter reports the delay is over, the controller reads the comparator and either clears the weight bit or keeps it. It then moves the weight one place down and adds it in as the next trial bit.

Clearing and keeping take the same number of states, so the time a conversion takes depends only on the settle delay and never on the analog input. After eight trials the weight register is empty. The controller then pulses end-of-conversion for one cycle, copies the final code into the result register, and starts the next conversion for as long as the enable input stays high.

Top module: `sar_seq_ctrl`

The states are:
- `ST_IDLE`: waits for enable.
- `ST_LOAD`: sets the code and the weight to 0x80.
- `ST_STROBE`: loads the DAC.
- `ST_SETTLE`: holds the settle request until the delay counter reports done.
- `ST_CHECK`: samples the comparator.
- `ST_CLEAR` or `ST_KEEP`: `ST_CLEAR` subtracts the weight; `ST_KEEP` is a dummy state of the same length.
- `ST_SHIFT`: moves the weight right.
- `ST_ADD`: adds the weight into the code.
- `ST_DONE`: pulses end-of-conversion.

The transitions are:
- IDLE to LOAD when enabled.
- LOAD to STROBE to SETTLE.
- SETTLE to CHECK on settle done.
- CHECK to KEEP when the comparator is high, or to CLEAR when it is low.
- KEEP or CLEAR to SHIFT to ADD.
- ADD to DONE if the weight is zero, otherwise ADD to STROBE.
- DONE to LOAD.
- Any state to IDLE when enable is low.

## Requirements
- R1: While reset is asserted, dac_code, dac_load, settle_go, conv_done and result are all zero.
- R2: While run_en is low, dac_load, settle_go and conv_done stay low from the next cycle on, whatever cmp_hi and settle_done do.
- R3: The first code strobed in every conversion is 0x80.
- R4: The k-th strobed code (k = 0..7) equals the bits already decided, with bit 7-k set and all lower bits clear.
- R5: A trial bit is kept when cmp_hi is high at the check and cleared when it is low. With cmp_hi = (input >= last strobed code), the result equals the input code.
- R6: With run_en held high and settle lasting W cycles, end-of-conversion pulses are exactly 2 + 8*(W+5) cycles apart, for any input.
- R7: dac_code does not change from the strobe cycle through the end of the settle window, and no more than one of dac_load, settle_go and conv_done is high at a time.
- R8: settle_go rises only in the cycle after a strobe, stays high until settle_done is seen, and is low in the next cycle.
- R9: conv_done is a one-cycle pulse after exactly eight strobes. result changes only at the clock edge that ends a conv_done cycle.
- R10: With run_en held high, the next conversion's strobe of 0x80 comes two cycles after conv_done.
- R11: Dropping run_en mid-conversion returns to idle with no conv_done and no change to result. The next enable starts over at 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Active-high run enable |
| cmp_hi | input | 1 | Comparator decision: input at or above the DAC level |
| settle_done | input | 1 | External delay counter reports that the settle delay has elapsed |
| dac_code | output | 8 | Trial code presented to the DAC |
| dac_load | output | 1 | One-cycle DAC load strobe |
| settle_go | output | 1 | Lets the external delay counter run |
| conv_done | output | 1 | One-cycle end-of-conversion pulse |
| result | output | 8 | Last completed conversion result |

## Verification
The properties assume that settle_done is honoured only while settle_go is high. They also assume that run_en and the comparator change away from the sampling edge. The stimulus meets both conditions:
- The bench's delay-counter model raises settle_done only while settle_go is high. It clears its count as soon as settle_go falls.
- Enable changes are made on the falling clock edge.
- The ideal comparator compares against the code latched at the last strobe, so it stays steady across the whole settle window.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LOAD,
        ST_STROBE,
        ST_SETTLE,
        ST_CHECK,
        ST_CLEAR,
        ST_KEEP,
        ST_SHIFT,
        ST_ADD,
        ST_DONE
    } sar_state_t;

endpackage

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
    import sar_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic cmp_hi,
    input  logic settle_done,
    input  logic mask_zero,
    output logic ld_init,
    output logic do_clear,
    output logic do_shift,
    output logic do_add,
    output logic dac_load,
    output logic settle_go,
    output logic conv_done
);

    sar_state_t state_q;
    sar_state_t state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // transitions; dropping the enable always wins
    always_comb begin
        state_nx = state_q;
        if (!run_en) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_nx = ST_LOAD;
                ST_LOAD:   state_nx = ST_STROBE;
                ST_STROBE: state_nx = ST_SETTLE;
                ST_SETTLE: state_nx = settle_done ? ST_CHECK : ST_SETTLE;
                ST_CHECK:  state_nx = cmp_hi ? ST_KEEP : ST_CLEAR;
                ST_CLEAR:  state_nx = ST_SHIFT;
                ST_KEEP:   state_nx = ST_SHIFT;
                ST_SHIFT:  state_nx = ST_ADD;
                ST_ADD:    state_nx = mask_zero ? ST_DONE : ST_STROBE;
                ST_DONE:   state_nx = ST_LOAD;
                default:   state_nx = ST_IDLE;
            endcase
        end
    end

    // Moore outputs
    always_comb begin
        ld_init   = 1'b0;
        do_clear  = 1'b0;
        do_shift  = 1'b0;
        do_add    = 1'b0;
        dac_load  = 1'b0;
        settle_go = 1'b0;
        conv_done = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_LOAD:   ld_init   = 1'b1;
            ST_STROBE: dac_load  = 1'b1;
            ST_SETTLE: settle_go = 1'b1;
            ST_CHECK:  ;
            ST_CLEAR:  do_clear  = 1'b1;
            ST_KEEP:   ;
            ST_SHIFT:  do_shift  = 1'b1;
            ST_ADD:    do_add    = 1'b1;
            ST_DONE:   conv_done = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/sar_seq_datapath.sv
module sar_seq_datapath #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_init,
    input  logic             do_clear,
    input  logic             do_shift,
    input  logic             do_add,
    output logic [WIDTH-1:0] code,
    output logic             mask_zero
);

    localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] code_q;
    logic [WIDTH-1:0] mask_q;

    // trial code register: subtract clears the bit under test, add sets the next one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (ld_init) begin
            code_q <= TOP_BIT;
        end else if (do_clear) begin
            code_q <= code_q - mask_q;
        end else if (do_add) begin
            code_q <= code_q + mask_q;
        end
    end

    // one-hot weight register doubles as the trial counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (ld_init) begin
            mask_q <= TOP_BIT;
        end else if (do_shift) begin
            mask_q <= mask_q >> 1;
        end
    end

    assign code      = code_q;
    assign mask_zero = (mask_q == '0);

endmodule

// File: rtl/sar_seq_result.sv
module sar_seq_result #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [WIDTH-1:0] code,
    output logic [WIDTH-1:0] result
);

    logic [WIDTH-1:0] result_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (capture) begin
            result_q <= code;
        end
    end

    assign result = result_q;

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             cmp_hi,
    input  logic             settle_done,
    output logic [WIDTH-1:0] dac_code,
    output logic             dac_load,
    output logic             settle_go,
    output logic             conv_done,
    output logic [WIDTH-1:0] result
);

    logic ld_init;
    logic do_clear;
    logic do_shift;
    logic do_add;
    logic mask_zero;

    sar_seq_fsm i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .cmp_hi      (cmp_hi),
        .settle_done (settle_done),
        .mask_zero   (mask_zero),
        .ld_init     (ld_init),
        .do_clear    (do_clear),
        .do_shift    (do_shift),
        .do_add      (do_add),
        .dac_load    (dac_load),
        .settle_go   (settle_go),
        .conv_done   (conv_done)
    );

    sar_seq_datapath #(.WIDTH(WIDTH)) i_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_init   (ld_init),
        .do_clear  (do_clear),
        .do_shift  (do_shift),
        .do_add    (do_add),
        .code      (dac_code),
        .mask_zero (mask_zero)
    );

    sar_seq_result #(.WIDTH(WIDTH)) i_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (conv_done),
        .code    (dac_code),
        .result  (result)
    );

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             settle_done,
    input logic [WIDTH-1:0] dac_code,
    input logic             dac_load,
    input logic             settle_go,
    input logic             conv_done,
    input logic [WIDTH-1:0] result
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !run_en |=> (!dac_load && !settle_go && !conv_done)); // R2
    AST_CODE_STEADY: assert property (@(posedge clk) disable iff (!rst_n) settle_go |-> $stable(dac_code)); // R7
    AST_EXCLUSIVE_CTRL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({dac_load, settle_go, conv_done})); // R7
    AST_TRIG_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n) $rose(settle_go) |-> $past(dac_load)); // R8
    AST_TRIG_DROP: assert property (@(posedge clk) disable iff (!rst_n) (settle_go && settle_done) |=> !settle_go); // R8
    AST_EOC_PULSE: assert property (@(posedge clk) disable iff (!rst_n) conv_done |=> !conv_done); // R9
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !conv_done |=> $stable(result)); // R9

endmodule

bind sar_seq_ctrl sar_seq_chk #(.WIDTH(WIDTH)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_en      (run_en),
    .settle_done (settle_done),
    .dac_code    (dac_code),
    .dac_load    (dac_load),
    .settle_go   (settle_go),
    .conv_done   (conv_done),
    .result      (result)
);

// File: tb/test_sar_seq_ctrl.sv
`timescale 1ns/1ps
module test_sar_seq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic       cmp_hi;
    logic       settle_done;
    logic [7:0] dac_code;
    logic       dac_load;
    logic       settle_go;
    logic       conv_done;
    logic [7:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int dly_lim  = 3;
    int ain      = 0;
    logic [7:0] dac_held = 8'h00;
    int dly_cnt  = 0;
    int done_cyc = 0;
    int first_strobe_cyc = 0;

    always #10 clk = ~clk;   // 50 MHz

    sar_seq_ctrl i_sar_seq_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .cmp_hi      (cmp_hi),
        .settle_done (settle_done),
        .dac_code    (dac_code),
        .dac_load    (dac_load),
        .settle_go   (settle_go),
        .conv_done   (conv_done),
        .result      (result)
    );

    // ideal DAC + comparator and delay counter models
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (dac_load) dac_held <= dac_code;
        if (!settle_go) dly_cnt <= 0;
        else            dly_cnt <= dly_cnt + 1;
    end
    assign cmp_hi      = (ain >= int'(dac_held));
    assign settle_done = settle_go && (dly_cnt == dly_lim);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // one full conversion of input a; leaves enable high if keep_en
    task automatic run_conv(input int a, input bit keep_en);
        int est = 0;
        int strobes = 0;
        int trig_run = 0;
        bit run_ok = 1'b1;
        bit got = 1'b0;
        int trial;
        logic [7:0] prev_res = result;
        ain = a;
        run_en = 1'b1;
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            if (dac_load) begin
                trial = (strobes < 8) ? (est | (128 >> strobes)) : -1;
                if (strobes == 0) begin
                    check(dac_code == 8'h80, "R3 first code", dac_code, 128);
                    first_strobe_cyc = cyc;
                end
                check(int'(dac_code) == trial, "R4 trial code", dac_code, trial);
                if (a >= trial) est = trial;
                strobes++;
            end
            if (settle_go) trig_run++;
            else if (trig_run != 0) begin
                if (trig_run != dly_lim + 1) run_ok = 1'b0;
                trig_run = 0;
            end
            if (conv_done) begin
                check(strobes == 8, "R9 strobes per conversion", strobes, 8);
                check(result == prev_res, "R9 result before EOC edge", result, prev_res);
                check(run_ok, "R8 settle window length", run_ok, 1);
                done_cyc = cyc;
                got = 1'b1;
                break;
            end
        end
        if (!got) check(1'b0, "R9 conversion never ended", 0, 1);
        @(negedge clk);
        check(int'(result) == a, "R5 result", result, a);
        check(int'(result) == est, "R5 binary search", result, est);
        check(!conv_done, "R9 single-cycle EOC", conv_done, 0);
        if (!keep_en) run_en = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        run_en = 1'b1;
        repeat (3) @(negedge clk);
        check(dac_code == 0 && !dac_load && !settle_go && !conv_done && result == 0,
              "R1 reset outputs", {dac_load, settle_go, conv_done}, 0);
        run_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_idle();
        bit quiet = 1'b1;
        run_en = 1'b0;
        for (int i = 0; i < 30; i++) begin
            ain = (i * 37) % 256;
            @(negedge clk);
            if (dac_load || settle_go || conv_done) quiet = 1'b0;
        end
        check(quiet, "R2 idle with enable low", quiet, 1);
    endtask

    task automatic t_singles();
        run_conv(0, 1'b0);
        run_conv(255, 1'b0);
        run_conv(128, 1'b0);
        run_conv(127, 1'b0);
        run_conv(1, 1'b0);
        run_conv(170, 1'b0);
    endtask

    task automatic t_back_to_back(input int dly);
        int d1;
        int d2;
        int expect_p = 2 + 8 * ((dly + 1) + 5);
        dly_lim = dly;
        run_conv(93, 1'b1);
        d1 = done_cyc;
        run_conv(0, 1'b1);
        check(first_strobe_cyc - d1 == 2, "R10 restart strobe delay", first_strobe_cyc - d1, 2);
        check(done_cyc - d1 == expect_p, "R6 period low input", done_cyc - d1, expect_p);
        d2 = done_cyc;
        run_conv(255, 1'b0);
        check(done_cyc - d2 == expect_p, "R6 period high input", done_cyc - d2, expect_p);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_abort();
        int strobes = 0;
        bit quiet = 1'b1;
        logic [7:0] prev_res;
        @(negedge clk);
        prev_res = result;
        ain = 200;
        run_en = 1'b1;
        for (int c = 0; c < 500 && strobes < 3; c++) begin
            @(negedge clk);
            if (dac_load) strobes++;
        end
        @(negedge clk);
        run_en = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (dac_load || settle_go || conv_done) quiet = 1'b0;
        end
        check(quiet, "R11 abort returns to idle", quiet, 1);
        check(result == prev_res, "R11 result kept on abort", result, prev_res);
        run_conv(77, 1'b0);   // R11 restart from 0x80 checked through R3/R4
    endtask

    initial begin
        t_reset();
        t_idle();
        t_singles();
        t_back_to_back(3);
        t_back_to_back(0);
        t_abort();
        t_idle();
        finish_run();
    end

    initial begin
        #(20 * 150000);
        check(1'b0, "watchdog expired", cyc, 0);
        finish_run();
    end

endmodule